// File: doc/BRIEF.md
# Write-Through Store Queue

This block sits between a write-through data cache and main memory. Every store the processor issues goes into the cache array, and a copy of it is queued here so that memory can be updated at its own pace. Memory takes entries one at a time, oldest first, through a request/acknowledge handshake. The processor is held back only when every slot is occupied and memory is not taking an entry in that same cycle. Because memory is always brought up to date this way, no line ever carries a modified flag.

When the cache misses on a load, the queue compares the load address with every pending entry in the same cycle. If any entry matches, the data of the most recently queued match is returned at once. If nothing matches, the block grants the memory read, but holds it back while a store to the same word is being presented, so that memory never returns a value older than a queued store. A mode input chooses between write-allocate and no-write-allocate. In no-write-allocate mode a store that misses the cache is queued but does not write the cache array.

Top module: `wt_store_queue`

## Requirements
- R1: During and straight after reset the queue is empty: `mem_wreq_o` and `stall_o` are 0.
- R2: A store with `st_valid_i`=1 and `stall_o`=0 is queued. `mem_wreq_o` is 1 whenever at least one entry is pending, and `mem_waddr_o`/`mem_wdata_o` show the oldest entry. That entry stays in place until a cycle with `mem_wreq_o`=1 and `mem_wack_i`=1, which removes exactly one entry.
- R3: `stall_o` is 1 exactly when DEPTH entries are pending and `mem_wack_i` is 0. A store presented while `stall_o`=1 is not queued.
- R4: When the queue is full, a cycle with `mem_wack_i`=1 and `st_valid_i`=1 removes the oldest entry and queues the new store. `stall_o` stays 0 in that cycle, and the queue is still full afterwards.
- R5: `cache_wr_o` is 1 exactly when a store is queued in that cycle and either `st_hit_i`=1 or `wr_alloc_i`=1. A store that misses with `wr_alloc_i`=0 is queued but does not write the cache.
- R6: While `rd_req_i`=1, `rd_fwd_o` is 1 in the same cycle if any pending entry has the address `rd_addr_i`. `rd_data_o` then carries the data of the most recently queued matching entry.
- R7: `rd_mem_ok_o` is 1 exactly when `rd_req_i`=1, no pending entry has the address `rd_addr_i`, and no store with that address is presented on `st_valid_i`/`st_addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Processor store presented |
| st_addr_i | input | 30 | Store word address |
| st_data_i | input | 32 | Store data |
| st_hit_i | input | 1 | Store address hits in the cache |
| wr_alloc_i | input | 1 | 1: write-allocate, 0: no-write-allocate |
| stall_o | output | 1 | Store cannot be accepted this cycle |
| cache_wr_o | output | 1 | Write the store into the cache array |
| rd_req_i | input | 1 | Load miss lookup request |
| rd_addr_i | input | 30 | Load miss word address |
| rd_fwd_o | output | 1 | A pending entry matches the load address |
| rd_data_o | output | 32 | Forwarded data from the newest match |
| rd_mem_ok_o | output | 1 | Load may be sent to memory |
| mem_wreq_o | output | 1 | Write request to memory (oldest entry) |
| mem_waddr_o | output | 30 | Oldest entry address |
| mem_wdata_o | output | 32 | Oldest entry data |
| mem_wack_i | input | 1 | Memory accepts the oldest entry |

## Verification
The assertions assume that `mem_wack_i` is sampled only together with `mem_wreq_o`, and that the store inputs are well defined whenever `st_valid_i` is high. The random stimulus drives every input on the falling edge with defined values. It confines addresses to a handful of words so that duplicate pending entries and load matches come up often, and it holds the acknowledge rate low enough that the queue keeps running full. Directed sequences add the cases where the queue fills up, a store and an acknowledge arrive together on a full queue, and several entries share one address.

// File: rtl/wb_pkg.sv
package wb_pkg;
  parameter int unsigned WB_AW = 30;
  parameter int unsigned WB_DW = 32;

  typedef struct packed {
    logic [WB_AW-1:0] addr;
    logic [WB_DW-1:0] data;
  } wb_entry_t;
endpackage

// File: rtl/wb_ptr_ctrl.sv
module wb_ptr_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = cnt_q;
  assign full_o   = (cnt_q == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |-> pop_i); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0)); // R2
endmodule

// File: rtl/wb_entry_ram.sv
module wb_entry_ram
  import wb_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  wb_entry_t     wdata_i,
  output wb_entry_t     ent_o [DEPTH]
);
  wb_entry_t mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == PW'(i)) mem_q[i] <= wdata_i;
    end
    assign ent_o[i] = mem_q[i];
  end
endmodule

// File: rtl/wb_fwd_match.sv
module wb_fwd_match
  import wb_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  wb_entry_t        ent_i [DEPTH],
  input  logic [PW-1:0]    rd_ptr_i,
  input  logic [CW-1:0]    count_i,
  input  logic [WB_AW-1:0] addr_i,
  output logic             hit_o,
  output logic [WB_DW-1:0] data_o
);
  // walk oldest to newest so the last match wins
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      automatic int unsigned s = (int'(rd_ptr_i) + k) % DEPTH;
      if (k < int'(count_i) && ent_i[s].addr == addr_i) begin
        hit_o  = 1'b1;
        data_o = ent_i[s].data;
      end
    end
  end
endmodule

// File: rtl/wt_store_queue.sv
module wt_store_queue
  import wb_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_valid_i,
  input  logic [WB_AW-1:0] st_addr_i,
  input  logic [WB_DW-1:0] st_data_i,
  input  logic             st_hit_i,
  input  logic             wr_alloc_i,
  output logic             stall_o,
  output logic             cache_wr_o,
  input  logic             rd_req_i,
  input  logic [WB_AW-1:0] rd_addr_i,
  output logic             rd_fwd_o,
  output logic [WB_DW-1:0] rd_data_o,
  output logic             rd_mem_ok_o,
  output logic             mem_wreq_o,
  output logic [WB_AW-1:0] mem_waddr_o,
  output logic [WB_DW-1:0] mem_wdata_o,
  input  logic             mem_wack_i
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             full, push, pop;
  logic             lk_hit;
  logic [WB_DW-1:0] lk_data;
  wb_entry_t        ents [DEPTH];
  wb_entry_t        wr_ent;

  assign stall_o    = full && !mem_wack_i;
  assign push       = st_valid_i && !stall_o;
  assign mem_wreq_o = (count != '0);
  assign pop        = mem_wreq_o && mem_wack_i;
  assign wr_ent     = '{addr: st_addr_i, data: st_data_i};

  wb_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr),
    .count_o(count), .full_o(full)
  );

  wb_entry_ram #(.DEPTH(DEPTH)) i_ram (
    .clk_i,
    .we_i(push), .waddr_i(wr_ptr), .wdata_i(wr_ent),
    .ent_o(ents)
  );

  wb_fwd_match #(.DEPTH(DEPTH)) i_match (
    .ent_i(ents), .rd_ptr_i(rd_ptr), .count_i(count),
    .addr_i(rd_addr_i), .hit_o(lk_hit), .data_o(lk_data)
  );

  assign mem_waddr_o = ents[rd_ptr].addr;
  assign mem_wdata_o = ents[rd_ptr].data;

  // no-write-allocate: store misses skip the cache array
  assign cache_wr_o  = push && (st_hit_i || wr_alloc_i);

  assign rd_fwd_o    = rd_req_i && lk_hit;
  assign rd_data_o   = lk_data;
  // hold memory read while a same-word store is in flight
  assign rd_mem_ok_o = rd_req_i && !lk_hit && !(st_valid_i && st_addr_i == rd_addr_i);

  AST_DRAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wreq_o && !mem_wack_i) |=> (mem_wreq_o && $stable(mem_waddr_o) && $stable(mem_wdata_o))); // R2
  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (count == $past(count))); // R3
  AST_FULL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && mem_wack_i && st_valid_i) |=> full); // R4
  AST_FWD_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fwd_o |-> mem_wreq_o); // R6
  AST_NWA_NO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !st_hit_i && !wr_alloc_i) |-> !cache_wr_o); // R5
  AST_RD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mem_ok_o |-> !rd_fwd_o); // R7
endmodule

// File: tb/test_wt_store_queue.sv
`timescale 1ns/1ps
module test_wt_store_queue;
  import wb_pkg::*;
  localparam int unsigned DEPTH = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic st_valid_i = 0, st_hit_i = 0, wr_alloc_i = 0, rd_req_i = 0, mem_wack_i = 0;
  logic [WB_AW-1:0] st_addr_i = '0, rd_addr_i = '0;
  logic [WB_DW-1:0] st_data_i = '0;
  logic stall_o, cache_wr_o, rd_fwd_o, rd_mem_ok_o, mem_wreq_o;
  logic [WB_DW-1:0] rd_data_o, mem_wdata_o;
  logic [WB_AW-1:0] mem_waddr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  wb_entry_t q[$];

  always #2 clk = ~clk;

  wt_store_queue #(.DEPTH(DEPTH)) i_wt_store_queue (
    .clk_i(clk), .rst_ni, .st_valid_i, .st_addr_i, .st_data_i, .st_hit_i,
    .wr_alloc_i, .stall_o, .cache_wr_o, .rd_req_i, .rd_addr_i, .rd_fwd_o,
    .rd_data_o, .rd_mem_ok_o, .mem_wreq_o, .mem_waddr_o, .mem_wdata_o, .mem_wack_i
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [WB_AW-1:0] a);
    foreach (q[i]) if (q[i].addr == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [WB_DW-1:0] exp_data(input logic [WB_AW-1:0] a);
    logic [WB_DW-1:0] d = '0;
    foreach (q[i]) if (q[i].addr == a) d = q[i].data;
    return d;
  endfunction

  // called at a falling edge; leaves at the next falling edge
  task automatic step(input bit sv, input logic [WB_AW-1:0] sa, input logic [WB_DW-1:0] sd,
                      input bit hit, input bit alloc, input bit rv,
                      input logic [WB_AW-1:0] ra, input bit ack);
    bit full_e, stall_e, push_e, hit_e;
    st_valid_i = sv; st_addr_i = sa; st_data_i = sd; st_hit_i = hit;
    wr_alloc_i = alloc; rd_req_i = rv; rd_addr_i = ra; mem_wack_i = ack;
    #0.5;
    full_e  = (q.size() == DEPTH);
    stall_e = full_e && !ack;
    push_e  = sv && !stall_e;
    hit_e   = exp_hit(ra);
    chk("R3 stall", stall_o, stall_e);
    if (full_e && ack && sv) chk("R4 full+ack store", stall_o, 0);
    chk("R2 wreq", mem_wreq_o, q.size() != 0);
    if (q.size() != 0) begin
      chk("R2 head addr", mem_waddr_o, q[0].addr);
      chk("R2 head data", mem_wdata_o, q[0].data);
    end
    chk("R5 cache_wr", cache_wr_o, push_e && (hit || alloc));
    chk("R6 fwd", rd_fwd_o, rv && hit_e);
    if (rv && hit_e) chk("R6 fwd data newest", rd_data_o, exp_data(ra));
    chk("R7 mem rd ok", rd_mem_ok_o, rv && !hit_e && !(sv && sa == ra));
    if (ack && q.size() != 0) void'(q.pop_front());
    if (push_e) q.push_back('{addr: sa, data: sd});
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #5;
    chk("R1 reset wreq", mem_wreq_o, 0);
    chk("R1 reset stall", stall_o, 0);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    chk("R1 post-reset wreq", mem_wreq_o, 0);

    // fill with duplicates, no drain; R6 newest match
    step(1, 30'd5, 32'h11, 1, 1, 0, 0, 0);
    step(1, 30'd6, 32'h22, 0, 0, 1, 30'd6, 0);   // R7 same-cycle store blocks read
    step(1, 30'd5, 32'h33, 0, 1, 1, 30'd5, 0);
    step(1, 30'd7, 32'h44, 0, 0, 1, 30'd5, 0);   // queue now full
    step(1, 30'd9, 32'h55, 1, 1, 1, 30'd5, 0);   // R3 stalled, dropped
    step(1, 30'd9, 32'h66, 1, 1, 1, 30'd8, 1);   // R4 full+ack
    chk("R4 still full", q.size(), DEPTH);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 stall when full no ack", stall_o, 1);
    // drain all in order
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 0, 1, 30'd5, 1);
    step(0, 0, 0, 0, 0, 1, 30'd9, 0);             // R7 empty -> mem read ok

    // random mix
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 2) != 0, WB_AW'($urandom_range(0, 5)), $urandom(),
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, WB_AW'($urandom_range(0, 5)),
           $urandom_range(0, 9) < 4);
    end
    done = 1;
    finish_run();
  end
endmodule